// File: doc/BRIEF.md
# Edge-Triggered Counter Snapshot Unit

This block takes a snapshot of a free-running 16-bit counter when a chosen edge appears on an external capture pin. The snapshot is held in two read-only bytes that a CPU reads over an 8-bit port. Each accepted snapshot raises a capture flag. When enabled, the flag drives an interrupt line. The counter itself is supplied from outside.

Two small state machines guard the CPU view so that reads stay coherent. The lock machine has states `LK_OPEN` and `LK_HELD`. A read of the high byte moves it from `LK_OPEN` to `LK_HELD`, and a read of the low byte moves it back. While it is held, snapshots are refused, so the high/low pair always comes from one capture. The flag machine has states `FL_CLEAR`, `FL_PENDING` and `FL_ARMED`:
- An allowed capture moves any state to `FL_PENDING`.
- A status read in `FL_PENDING` moves it to `FL_ARMED`.
- A low-byte read in `FL_ARMED`, with no capture in the same cycle, returns it to `FL_CLEAR`.

The capture pin passes through a two-flop synchroniser and then a previous-value flop. A capture therefore lands on the third rising clock edge after the pin changes.

Top module: `icap_unit`

## Requirements
- R1: On an active edge, the full 16-bit `cnt_val` is stored in one cycle. The register update occurs on the third rising clock edge after the pin change is presented.
- R2: With `edge_rising`=1 only a 0-to-1 pin change captures, and with `edge_rising`=0 only a 1-to-0 change captures. The opposite edge changes nothing.
- R3: A CPU read of address 0x14 (high byte) enters `LK_HELD`. Edges that arrive while held are dropped and are not replayed later.
- R4: A CPU read of address 0x15 (low byte) returns the lock to `LK_OPEN`, and later edges capture again.
- R5: Every allowed capture sets `cap_flag`. `irq` is high exactly when `cap_flag` and `irq_en` are both high.
- R6: A `stat_rd` pulse while the flag is set, followed in a later cycle by a low-byte read, clears the flag.
- R7: A low-byte read that is not preceded by a qualifying status read leaves the flag set.
- R8: If a capture and an arming low-byte read fall in the same cycle, the flag stays set. A fresh status read is then needed before a low-byte read can clear it.
- R9: CPU writes to 0x14 or 0x15 change neither the stored bytes nor the flag.
- R10: Reset clears the flag and the lock but leaves the stored snapshot bytes unchanged.
- R11: `cpu_rdata` shows the high byte at 0x14, the low byte at 0x15 and 0x00 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | CPU byte address |
| cpu_rd | input | 1 | CPU read strobe, one cycle per access |
| cpu_wr | input | 1 | CPU write strobe (ignored) |
| cpu_wdata | input | 8 | CPU write data (ignored) |
| cpu_rdata | output | 8 | Read data for the addressed byte |
| stat_rd | input | 1 | Status register read strobe |
| edge_rising | input | 1 | Active edge select: 1 rising, 0 falling |
| cnt_val | input | 16 | Free-running counter value |
| cap_pin | input | 1 | Asynchronous capture pin |
| irq_en | input | 1 | Interrupt enable |
| cap_flag | output | 1 | Capture flag |
| irq | output | 1 | Interrupt request |

## Verification
A table of edges is walked under both polarities, including same-polarity repeats and opposite-edge transitions. This separates a detector that captures on any change from one that honours `edge_rising`. Counter values of all ones, all zeros and single-byte patterns expose byte swaps or partial latching. Directed sequences then place edges inside a held window and check afterwards whether a dropped edge reappears. They also put a capture and an armed low-byte read in the same cycle, which distinguishes "capture wins" from "clear wins" and shows whether arming survives the collision.

// File: rtl/icap_pkg.sv
package icap_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_CAP_HI = 8'h14;
    localparam logic [ADDR_W-1:0] ADDR_CAP_LO = 8'h15;

    typedef enum logic {
        LK_OPEN,
        LK_HELD
    } lock_state_t;

    typedef enum logic [1:0] {
        FL_CLEAR,
        FL_PENDING,
        FL_ARMED
    } flag_state_t;
endpackage

// File: rtl/icap_edge.sv
module icap_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rising,
    output logic edge_hit
);
    logic [SYNC_STAGES-1:0] chain;
    logic                   prev;
    logic                   cur;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= pin;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[SYNC_STAGES-2:0], pin};
            end
        end
    endgenerate

    assign cur = chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) prev <= 1'b0;
        else        prev <= cur;
    end

    always_comb begin
        if (rising) edge_hit = cur & ~prev;
        else        edge_hit = ~cur & prev;
    end

    assert_edge_is_change_R2: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> (prev != $past(prev)));
endmodule

// File: rtl/icap_lock_fsm.sv
module icap_lock_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_rd,
    input  logic lo_rd,
    output logic held
);
    lock_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (hi_rd) state_d = LK_HELD;
            LK_HELD: if (lo_rd) state_d = LK_OPEN;
            default: state_d = LK_OPEN;
        endcase
    end

    always_comb begin
        held = (state_q == LK_HELD);
    end

    assert_lock_on_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_rd && !lo_rd) |=> held);
    assert_unlock_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lo_rd |=> !held);
endmodule

// File: rtl/icap_flag_fsm.sv
module icap_flag_fsm
    import icap_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_fire,
    input  logic stat_rd,
    input  logic lo_rd,
    output logic flag
);
    flag_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (cap_fire) state_d = FL_PENDING;
            end
            FL_PENDING: begin
                if (cap_fire)     state_d = FL_PENDING;
                else if (stat_rd) state_d = FL_ARMED;
            end
            FL_ARMED: begin
                if (cap_fire)   state_d = FL_PENDING;
                else if (lo_rd) state_d = FL_CLEAR;
            end
            default: state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        flag = (state_q != FL_CLEAR);
    end

    assert_set_on_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> flag);
    assert_no_clear_unarmed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_PENDING && lo_rd) |=> flag);
    assert_capture_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_ARMED && lo_rd && cap_fire) |=> (state_q == FL_PENDING));
endmodule

// File: rtl/icap_unit.sv
module icap_unit
    import icap_pkg::*;
#(
    parameter int                 SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0]  HI_ADDR     = ADDR_CAP_HI,
    parameter logic [ADDR_W-1:0]  LO_ADDR     = ADDR_CAP_LO
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              stat_rd,
    input  logic              edge_rising,
    input  logic [2*BYTE_W-1:0] cnt_val,
    input  logic              cap_pin,
    input  logic              irq_en,
    output logic              cap_flag,
    output logic              irq
);
    localparam int CNT_W = 2 * BYTE_W;

    logic              edge_hit;
    logic              held;
    logic              hi_rd;
    logic              lo_rd;
    logic              cap_fire;
    logic [BYTE_W-1:0] cap_hi;
    logic [BYTE_W-1:0] cap_lo;
    logic              unused_wr_bus;

    assign hi_rd    = cpu_rd && (cpu_addr == HI_ADDR);
    assign lo_rd    = cpu_rd && (cpu_addr == LO_ADDR);
    assign cap_fire = edge_hit && !held;
    assign unused_wr_bus = ^{cpu_wr, cpu_wdata};

    icap_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (cap_pin),
        .rising   (edge_rising),
        .edge_hit (edge_hit)
    );

    icap_lock_fsm u_lock (
        .clk   (clk),
        .rst_n (rst_n),
        .hi_rd (hi_rd),
        .lo_rd (lo_rd),
        .held  (held)
    );

    icap_flag_fsm u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_fire (cap_fire),
        .stat_rd  (stat_rd),
        .lo_rd    (lo_rd),
        .flag     (cap_flag)
    );

    // Snapshot bytes deliberately carry no reset.
    always_ff @(posedge clk) begin
        if (cap_fire) begin
            cap_hi <= cnt_val[CNT_W-1:BYTE_W];
            cap_lo <= cnt_val[BYTE_W-1:0];
        end
    end

    always_comb begin
        if (cpu_addr == HI_ADDR)      cpu_rdata = cap_hi;
        else if (cpu_addr == LO_ADDR) cpu_rdata = cap_lo;
        else                          cpu_rdata = '0;
    end

    assign irq = cap_flag & irq_en;

    assert_capture_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fire |=> ({cap_hi, cap_lo} == $past(cnt_val)));
    assert_hold_while_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        held |=> $stable({cap_hi, cap_lo}));
    assert_write_no_effect_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && !edge_hit) |=> $stable({cap_hi, cap_lo}));
endmodule

// File: tb/test_icap_unit.sv
`timescale 1ns/1ps
module test_icap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cpu_addr = 8'h00;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = 8'h00;
    logic [7:0]  cpu_rdata;
    logic        stat_rd = 1'b0;
    logic        edge_rising = 1'b1;
    logic [15:0] cnt_val = 16'h0000;
    logic        cap_pin = 1'b0;
    logic        irq_en = 1'b1;
    logic        cap_flag;
    logic        irq;

    always #2 clk = ~clk;

    icap_unit i_icap_unit (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .stat_rd(stat_rd), .edge_rising(edge_rising), .cnt_val(cnt_val),
        .cap_pin(cap_pin), .irq_en(irq_en), .cap_flag(cap_flag), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] m_cap = 16'h0000;
    logic m_flag = 1'b0;
    logic m_arm = 1'b0;
    logic m_lock = 1'b0;
    logic cur_pin = 1'b0;
    logic [7:0] rb;

    // {polarity, new pin level, counter value}
    localparam logic [17:0] VEC [8] = '{
        {1'b1, 1'b1, 16'h1234},
        {1'b1, 1'b0, 16'hBEEF},
        {1'b1, 1'b1, 16'hFFFF},
        {1'b0, 1'b0, 16'h8001},
        {1'b0, 1'b1, 16'hCAFE},
        {1'b0, 1'b0, 16'h0000},
        {1'b1, 1'b1, 16'h00FF},
        {1'b1, 1'b0, 16'hA55A}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd_byte(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
        if (a == 8'h14) m_lock = 1'b1;
        if (a == 8'h15) begin
            m_lock = 1'b0;
            if (m_arm && m_flag) m_flag = 1'b0;
            m_arm = 1'b0;
        end
    endtask

    task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic stat_pulse();
        @(negedge clk);
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
        if (m_flag) m_arm = 1'b1;
    endtask

    task automatic drive_edge(input logic lvl, input logic [15:0] c);
        @(negedge clk);
        cnt_val = c; cap_pin = lvl;
        repeat (3) @(posedge clk);
        #1;
        if (lvl != cur_pin && lvl == edge_rising && !m_lock) begin
            m_cap = c; m_flag = 1'b1; m_arm = 1'b0;
        end
        cur_pin = lvl;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_flag = 1'b0; m_arm = 1'b0; m_lock = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 flag after reset", cap_flag, 1'b0);
        chk("R10 irq after reset", irq, 1'b0);

        // Table walk: R1 R2 R5 R6
        foreach (VEC[i]) begin
            edge_rising = VEC[i][17];
            drive_edge(VEC[i][16], VEC[i][15:0]);
            chk("R5 flag", cap_flag, m_flag);
            chk("R5 irq", irq, m_flag);
            rd_byte(8'h14, rb);
            chk("R1 R2 high byte", rb, m_cap[15:8]);
            rd_byte(8'h15, rb);
            chk("R1 R2 low byte", rb, m_cap[7:0]);
            stat_pulse();
            rd_byte(8'h15, rb);
            chk("R6 flag cleared", cap_flag, 1'b0);
        end

        // R7: low read without status read
        edge_rising = 1'b1;
        drive_edge(1'b1, 16'h4321);
        rd_byte(8'h15, rb);
        chk("R7 flag kept", cap_flag, 1'b1);
        stat_pulse();
        rd_byte(8'h15, rb);
        chk("R6 clear after arm", cap_flag, 1'b0);

        // R3 R4: lock, dropped edge, unlock
        rd_byte(8'h14, rb);
        drive_edge(1'b0, 16'h0101);
        drive_edge(1'b1, 16'h5A5A);
        chk("R3 flag while held", cap_flag, 1'b0);
        rd_byte(8'h15, rb);
        chk("R3 low unchanged", rb, 8'h21);
        repeat (5) @(posedge clk);
        rd_byte(8'h14, rb);
        chk("R3 not replayed high", rb, 8'h43);
        rd_byte(8'h15, rb);
        chk("R3 not replayed low", rb, 8'h21);
        drive_edge(1'b0, 16'h0202);
        drive_edge(1'b1, 16'h3C3C);
        rd_byte(8'h14, rb);
        chk("R4 capture after unlock", rb, 8'h3C);
        rd_byte(8'h15, rb);

        // R9: writes ignored
        wr_byte(8'h14, 8'hAA);
        wr_byte(8'h15, 8'h55);
        rd_byte(8'h14, rb);
        chk("R9 high after write", rb, 8'h3C);
        rd_byte(8'h15, rb);
        chk("R9 low after write", rb, 8'h3C);
        chk("R9 flag after write", cap_flag, m_flag);

        // R11: unmapped address
        rd_byte(8'h16, rb);
        chk("R11 unmapped read", rb, 8'h00);

        // R5: interrupt enable gating
        irq_en = 1'b0;
        #1 chk("R5 irq masked", irq, 1'b0);
        irq_en = 1'b1;
        #1 chk("R5 irq enabled", irq, 1'b1);

        // R8: capture and armed low read collide
        stat_pulse();
        drive_edge(1'b0, 16'h0303);
        @(negedge clk);
        cnt_val = 16'h7777; cap_pin = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        cpu_addr = 8'h15; cpu_rd = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        m_cap = 16'h7777; m_flag = 1'b1; m_arm = 1'b0; m_lock = 1'b0; cur_pin = 1'b1;
        chk("R8 flag survives collision", cap_flag, 1'b1);
        rd_byte(8'h15, rb);
        chk("R8 low byte new", rb, 8'h77);
        chk("R8 disarmed by capture", cap_flag, 1'b1);

        // R10: reset clears lock and flag, keeps snapshot
        drive_edge(1'b0, 16'h0404);
        rd_byte(8'h14, rb);
        do_reset();
        @(negedge clk);
        chk("R10 flag cleared", cap_flag, 1'b0);
        drive_edge(1'b1, 16'h1111);
        chk("R10 lock cleared", cap_flag, 1'b1);
        drive_edge(1'b0, 16'h0505);
        do_reset();
        @(negedge clk);
        rd_byte(8'h14, rb);
        chk("R10 high retained", rb, 8'h11);
        rd_byte(8'h15, rb);
        chk("R10 low retained", rb, 8'h11);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule